// File: doc/BRIEF.md
# Pipelined Karatsuba Single-Precision Multiplier

This block multiplies two 32-bit binary floating-point numbers (1 sign bit, 8-bit exponent biased by 127, 23 stored fraction bits behind an implied leading one) and returns a 32-bit product. It takes one operand pair per clock and has no stall. Each operand pair is qualified by `in_valid`, and its result appears on `out_res` with `out_valid` exactly eight cycles later.

The sign and the exponent are worked out on their own paths. The sign is the XOR of the input signs. The exponent is the sum of the two biased exponents minus 127. The two 24-bit significands are each cut into three 8-bit lanes. Three lane-by-lane products and three products of lane-pair sums give the full 48-bit significand product, and no multiplier wider than 9 by 9 bits is needed. The product is then normalised, truncated and packed. Special operands are handled with a small fixed policy: subnormals count as zero, rounding is toward zero, and there are no flags.

Top module: `kfp_mul`

## Requirements
- R1: For every result that is not a NaN, bit 31 of `out_res` is the XOR of bit 31 of the two operands.
- R2: For finite non-zero operands whose product is in range, the exponent field `out_res[30:23]` equals ea + eb - 127, plus one when the significand product is 2.0 or more.
- R3: When the 48-bit significand product (1.fa × 1.fb scaled by 2^46) is below 2.0, the fraction `out_res[22:0]` is product bits [45:23], truncated.
- R4: When the significand product is 2.0 or more (bit 47 set), the fraction is product bits [46:24] and the exponent is incremented by one.
- R5: An operand whose exponent field is 0 (zero or subnormal), with no infinite or NaN operand, gives a zero result with the R1 sign and all other bits 0.
- R6: An operand with exponent field 255 and a non-zero fraction, or a zero operand times an infinite operand, gives the quiet NaN 0x7FC00000. Otherwise an infinite operand gives a signed infinity (exponent 255, fraction 0).
- R7: A finite computed exponent of 255 or more gives a signed infinity.
- R8: A finite computed exponent of 0 or less gives a signed zero.
- R9: `out_valid` in cycle t+8 equals `in_valid` in cycle t after reset. Pairs presented on consecutive cycles each produce their own result in order.
- R10: A synchronous active-high `rst` clears every in-flight valid bit, so no result from a pair accepted before the reset edge ever appears, and `out_valid` is 0 while `rst` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 32 | Product |

## Verification
In one cycle the pipeline can be emitting the result of an older pair while a reset edge discards the younger pairs behind it. The bench provokes this by applying `rst` in the middle of a gap-free stream. It expects the pair eight cycles ahead of the reset to still come out correctly and every later in-flight pair to vanish. A second collision is normalisation meeting the range limits. Exponent sweeps against significands near 2.0 push the increment of R4 into the overflow of R7, and products just above the underflow bound land on R8. Each result is judged against an arithmetic model built on a direct 64-bit integer multiply.

// File: rtl/kfp_pkg.sv
package kfp_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int DATA_W = 1 + EXP_W + FRAC_W;
  localparam int MANT_W = FRAC_W + 1;
  localparam int NLANE  = 3;
  localparam int LANE_W = MANT_W / NLANE;
  localparam int PROD_W = 2 * MANT_W;
  localparam int EW     = EXP_W + 3;   // signed working exponent
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef enum logic [1:0] {CLS_NUM, CLS_ZERO, CLS_INF, CLS_NAN} cls_e;

  typedef struct packed {
    logic                 sign;
    logic signed [EW-1:0] exp;
    cls_e                 cls;
  } side_t;

  localparam int SIDE_W = $bits(side_t);

  localparam logic [DATA_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
endpackage

// File: rtl/kfp_unpack.sv
module kfp_unpack
  import kfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_v,
  output side_t             out_side,
  output logic [MANT_W-1:0] out_ma,
  output logic [MANT_W-1:0] out_mb
);
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic za, zb, ia, ib, na, nb;
  side_t side_c;

  always_comb begin
    ea = in_a[DATA_W-2 -: EXP_W];
    eb = in_b[DATA_W-2 -: EXP_W];
    fa = in_a[FRAC_W-1:0];
    fb = in_b[FRAC_W-1:0];
    za = (ea == '0);
    zb = (eb == '0);
    ia = (ea == EXP_W'(EXP_MAX)) && (fa == '0);
    ib = (eb == EXP_W'(EXP_MAX)) && (fb == '0);
    na = (ea == EXP_W'(EXP_MAX)) && (fa != '0);
    nb = (eb == EXP_W'(EXP_MAX)) && (fb != '0);
    side_c.sign = in_a[DATA_W-1] ^ in_b[DATA_W-1];
    side_c.exp  = EW'(ea) + EW'(eb) - EW'(BIAS);
    if (na || nb || (za && ib) || (ia && zb)) side_c.cls = CLS_NAN;
    else if (ia || ib)                        side_c.cls = CLS_INF;
    else if (za || zb)                        side_c.cls = CLS_ZERO;
    else                                      side_c.cls = CLS_NUM;
  end

  always_ff @(posedge clk) begin
    if (rst) out_v <= 1'b0;
    else     out_v <= in_valid;
    out_side <= side_c;
    out_ma   <= {1'b1, fa};
    out_mb   <= {1'b1, fb};
  end
endmodule

// File: rtl/kfp_kara.sv
module kfp_kara
  import kfp_pkg::*;
#(
  parameter int unsigned SB_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_v,
  input  logic [MANT_W-1:0] xa,
  input  logic [MANT_W-1:0] xb,
  input  logic [SB_W-1:0]   in_sb,
  output logic              out_v,
  output logic [PROD_W-1:0] prod,
  output logic [SB_W-1:0]   out_sb
);
  localparam int LW  = LANE_W;
  localparam int SW  = LW + 1;
  localparam int DW  = 2 * LW;
  localparam int QW  = 2 * SW;
  localparam int STG = 4;

  // pair k combines lanes lo_of(k) and hi_of(k): (0,1) (0,2) (1,2)
  function automatic int lo_of(input int k);
    return (k == 2) ? 1 : 0;
  endfunction
  function automatic int hi_of(input int k);
    return (k == 0) ? 1 : 2;
  endfunction

  logic [LW-1:0] la [NLANE];
  logic [LW-1:0] lb [NLANE];
  logic [LW-1:0] r_la [NLANE];
  logic [LW-1:0] r_lb [NLANE];
  logic [SW-1:0] r_sa [NLANE];
  logic [SW-1:0] r_sb [NLANE];
  logic [DW-1:0] dp [NLANE];
  logic [QW-1:0] qp [NLANE];
  logic [DW-1:0] dd [NLANE];
  logic [QW-1:0] cx [NLANE];
  logic [STG-1:0] vp;
  logic [SB_W-1:0] sbp [STG];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign la[g] = xa[g*LW +: LW];
    assign lb[g] = xb[g*LW +: LW];
  end

  // stage 1: lanes and lane-pair sums
  always_ff @(posedge clk) begin
    for (int k = 0; k < NLANE; k++) begin
      r_la[k] <= la[k];
      r_lb[k] <= lb[k];
      r_sa[k] <= SW'(la[lo_of(k)]) + SW'(la[hi_of(k)]);
      r_sb[k] <= SW'(lb[lo_of(k)]) + SW'(lb[hi_of(k)]);
    end
  end

  // stage 2: six narrow products
  always_ff @(posedge clk) begin
    for (int k = 0; k < NLANE; k++) begin
      dp[k] <= DW'(r_la[k]) * DW'(r_lb[k]);
      qp[k] <= QW'(r_sa[k]) * QW'(r_sb[k]);
    end
  end

  // stage 3: cross terms by subtraction
  always_ff @(posedge clk) begin
    for (int k = 0; k < NLANE; k++) begin
      dd[k] <= dp[k];
      cx[k] <= qp[k] - QW'(dp[lo_of(k)]) - QW'(dp[hi_of(k)]);
    end
  end

  // stage 4: weighted recombination
  always_ff @(posedge clk) begin
    prod <= (PROD_W'(dd[2]) << (4*LW))
          + (PROD_W'(cx[2]) << (3*LW))
          + ((PROD_W'(cx[1]) + PROD_W'(dd[1])) << (2*LW))
          + (PROD_W'(cx[0]) << LW)
          + PROD_W'(dd[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) vp <= '0;
    else     vp <= {vp[STG-2:0], in_v};
    sbp[0] <= in_sb;
    for (int s = 1; s < STG; s++) sbp[s] <= sbp[s-1];
  end

  assign out_v  = vp[STG-1];
  assign out_sb = sbp[STG-1];

  // R3: split-and-recombine equals the direct product of the inputs
  p_kara_exact_r3: assert property (@(posedge clk) disable iff (rst)
    out_v |-> prod == (PROD_W'($past(xa, 4)) * PROD_W'($past(xb, 4))));
endmodule

// File: rtl/kfp_pack.sv
module kfp_pack
  import kfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_v,
  input  logic [PROD_W-1:0] prod,
  input  side_t             side,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_res
);
  localparam logic signed [EW-1:0] EXP_TOP = EW'(EXP_MAX);

  logic                 n_v, n_sign;
  cls_e                 n_cls;
  logic signed [EW-1:0] n_exp;
  logic [FRAC_W-1:0]    n_frac;
  logic                 p_v;
  logic [DATA_W-1:0]    p_res;
  logic                 hi;

  assign hi = prod[PROD_W-1];

  // normalise
  always_ff @(posedge clk) begin
    if (rst) n_v <= 1'b0;
    else     n_v <= in_v;
    n_sign <= side.sign;
    n_cls  <= side.cls;
    n_exp  <= side.exp + (hi ? EW'(1) : EW'(0));
    n_frac <= hi ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];
  end

  // classify range and pack
  always_ff @(posedge clk) begin
    if (rst) p_v <= 1'b0;
    else     p_v <= n_v;
    unique case (n_cls)
      CLS_NAN:  p_res <= QNAN;
      CLS_INF:  p_res <= {n_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_ZERO: p_res <= {n_sign, {(DATA_W-1){1'b0}}};
      default: begin
        if (n_exp >= EXP_TOP)
          p_res <= {n_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (n_exp <= 0)
          p_res <= {n_sign, {(DATA_W-1){1'b0}}};
        else
          p_res <= {n_sign, n_exp[EXP_W-1:0], n_frac};
      end
    endcase
  end

  // registered output
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= p_v;
    out_res <= p_res;
  end

  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (rst)
    (n_v && n_cls == CLS_NUM && n_exp >= EXP_TOP)
      |=> p_res[DATA_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

  p_udf_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (n_v && n_cls == CLS_NUM && n_exp <= 0)
      |=> p_res[DATA_W-2:0] == '0);

  p_nan_r6: assert property (@(posedge clk) disable iff (rst)
    (n_v && n_cls == CLS_NAN) |=> p_res == QNAN);

  p_fwd_r9: assert property (@(posedge clk) disable iff (rst)
    p_v |=> out_valid && $stable(out_res) == 1'b0 || out_res == $past(p_res));
endmodule

// File: rtl/kfp_mul.sv
module kfp_mul
  import kfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_res
);
  localparam int LAT = 8;

  logic              u_v, k_v;
  side_t             u_side, k_side;
  logic [MANT_W-1:0] u_ma, u_mb;
  logic [PROD_W-1:0] k_prod;
  logic [SIDE_W-1:0] k_sb;

  kfp_unpack u_unpack (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_v(u_v), .out_side(u_side), .out_ma(u_ma), .out_mb(u_mb)
  );

  kfp_kara #(.SB_W(SIDE_W)) u_kara (
    .clk(clk), .rst(rst), .in_v(u_v), .xa(u_ma), .xb(u_mb),
    .in_sb(u_side), .out_v(k_v), .prod(k_prod), .out_sb(k_sb)
  );

  assign k_side = side_t'(k_sb);

  kfp_pack u_pack (
    .clk(clk), .rst(rst), .in_v(k_v), .prod(k_prod), .side(k_side),
    .out_valid(out_valid), .out_res(out_res)
  );

  // cycles since reset, for the latency check window
  logic [3:0] warm;
  logic       rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)             warm <= '0;
    else if (warm < LAT) warm <= warm + 4'd1;
  end

  p_lat_r9: assert property (@(posedge clk) disable iff (rst)
    (warm == 4'(LAT)) |-> out_valid == $past(in_valid, 8));

  p_rst_clr_r10: assert property (@(posedge clk)
    rst_q |-> !out_valid);
endmodule

// File: tb/kfp_mul_tb.sv
`timescale 1ns/1ps
module kfp_mul_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_a, in_b;
  logic        out_valid;
  logic [31:0] out_res;

  always #2 clk = ~clk;   // 250 MHz

  kfp_mul u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_res(out_res)
  );

  int unsigned n_chk = 0, n_bad = 0;
  int unsigned cyc = 0;
  int unsigned rst_age = 100;
  logic [31:0] seed = 32'h1234_5678;
  bit          done = 1'b0;
  logic        hv [16];
  logic [31:0] ha [16];
  logic [31:0] hb [16];

  function automatic logic [31:0] lcg();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // arithmetic reference; tag names the governing requirement
  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                          output string tag);
    logic [7:0]  ea = a[30:23], eb = b[30:23];
    logic [22:0] fa = a[22:0], fb = b[22:0];
    logic        s = a[31] ^ b[31];
    logic [63:0] p;
    int          e;
    logic [22:0] f;
    bit na = (ea == 8'hFF) && (fa != 0), nb = (eb == 8'hFF) && (fb != 0);
    bit ia = (ea == 8'hFF) && (fa == 0), ib = (eb == 8'hFF) && (fb == 0);
    bit za = (ea == 0), zb = (eb == 0);
    if (na || nb || (za && ib) || (ia && zb)) begin tag = "R6"; return 32'h7FC0_0000; end
    if (ia || ib) begin tag = "R6"; return {s, 8'hFF, 23'd0}; end
    if (za || zb) begin tag = "R5"; return {s, 31'd0}; end
    p = {40'd0, 1'b1, fa} * {40'd0, 1'b1, fb};
    e = int'(ea) + int'(eb) - 127;
    if (p[47]) begin e = e + 1; f = p[46:24]; tag = "R4"; end
    else       begin f = p[45:23]; tag = "R3"; end
    if (e >= 255) begin tag = "R7"; return {s, 8'hFF, 23'd0}; end
    if (e <= 0)   begin tag = "R8"; return {s, 31'd0}; end
    return {s, e[7:0], f};
  endfunction

  task automatic check_slot();
    int unsigned k = (cyc + 8) & 15;   // entry driven 8 steps ago
    string tag;
    logic [31:0] exp_r;
    n_chk++;
    if (out_valid !== hv[k]) begin
      n_bad++;
      $display("FAIL %s: out_valid=%b expected %b (step %0d)",
               (rst_age <= 9) ? "R10" : "R9", out_valid, hv[k], cyc);
    end else if (hv[k]) begin
      exp_r = ref_mul(ha[k], hb[k], tag);
      if (exp_r[30:23] != 8'hFF || exp_r[22:0] == 0) begin
        if (out_res[31] !== exp_r[31]) tag = "R1";
        else if (tag == "R3" || tag == "R4")
          if (out_res[30:23] !== exp_r[30:23]) tag = "R2";
      end
      if (out_res !== exp_r) begin
        n_bad++;
        $display("FAIL %s: a=%h b=%h got %h expected %h", tag, ha[k], hb[k], out_res, exp_r);
      end
    end
  endtask

  task automatic step(input logic v, input logic r, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    check_slot();
    if (r) begin
      for (int i = 0; i < 16; i++) hv[i] = 1'b0;
      rst_age = 0;
    end else rst_age++;
    hv[cyc & 15] = v && !r;
    ha[cyc & 15] = a;
    hb[cyc & 15] = b;
    rst = r; in_valid = v; in_a = a; in_b = b;
    cyc++;
  endtask

  function automatic logic [31:0] mk(input logic s, input logic [7:0] e, input logic [22:0] f);
    return {s, e, f};
  endfunction

  logic [22:0] corner [8] = '{23'h000000, 23'h7FFFFF, 23'h7F0000, 23'h00FF00,
                              23'h0000FF, 23'h555555, 23'h2AAAAA, 23'h400000};
  logic [7:0]  ebs [8] = '{8'd0, 8'd1, 8'd64, 8'd127, 8'd128, 8'd200, 8'd254, 8'd255};

  initial begin
    for (int i = 0; i < 16; i++) begin hv[i] = 1'b0; ha[i] = '0; hb[i] = '0; end
    rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0;
    // R10: reset state, out_valid low while reset held
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, '0, '0);
    // R1 R2 R3 R4: back-to-back normal operands, random fractions and signs
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] x = lcg(), y = lcg(), z = lcg();
      step(1'b1, 1'b0, mk(z[0], 8'd100 + 8'(x[31:26]), x[22:0]),
                       mk(z[1], 8'd100 + 8'(y[31:26]), y[22:0]));
    end
    // R2 R5 R6 R7 R8: exponent sweep against fixed exponent set
    for (int ea = 0; ea < 256; ea++)
      for (int j = 0; j < 8; j++) begin
        logic [31:0] x = lcg(), y = lcg();
        step(1'b1, 1'b0, mk(x[31], 8'(ea), (j == 3) ? 23'd0 : x[22:0]),
                         mk(y[31], ebs[j], (x[5:0] == 0) ? 23'd0 : y[22:0]));
      end
    // R3 R4: lane-boundary significand patterns, all pairs
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        step(1'b1, 1'b0, mk(i[0], 8'd127, corner[i]), mk(j[1], 8'd130, corner[j]));
    // R7: product near 2.0 lifting exponent exactly to 255; R8: just at bound
    step(1'b1, 1'b0, mk(1'b0, 8'd191, 23'h7FFFFF), mk(1'b1, 8'd190, 23'h7FFFFF));
    step(1'b1, 1'b0, mk(1'b0, 8'd190, 23'h000000), mk(1'b0, 8'd191, 23'h000000));
    step(1'b1, 1'b0, mk(1'b1, 8'd63,  23'h000000), mk(1'b0, 8'd64,  23'h000000));
    step(1'b1, 1'b0, mk(1'b1, 8'd63,  23'h7FFFFF), mk(1'b0, 8'd64,  23'h7FFFFF));
    step(1'b1, 1'b0, mk(1'b0, 8'd0,   23'h000000), mk(1'b1, 8'd255, 23'h000000));
    step(1'b1, 1'b0, mk(1'b1, 8'd255, 23'h000000), mk(1'b1, 8'd255, 23'h000000));
    // R9: irregular gaps in the valid stream
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] x = lcg(), y = lcg();
      step(x[9] ^ y[3], 1'b0, mk(x[31], 8'd110 + 8'(x[28:24]), x[22:0]),
                              mk(y[31], 8'd110 + 8'(y[28:24]), y[22:0]));
    end
    // R10: reset in the middle of a full stream
    for (int n = 0; n < 3; n++) begin
      for (int i = 0; i < 12; i++) begin
        logic [31:0] x = lcg(), y = lcg();
        step(1'b1, 1'b0, mk(x[31], 8'd120, x[22:0]), mk(y[31], 8'd125, y[22:0]));
      end
      for (int i = 0; i <= n; i++) step(1'b1, 1'b1, lcg(), lcg());
    end
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, '0, '0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, got step %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule